// File: doc/BRIEF.md
# Configurable Logic Cell with Carry and Chain

This block is one programmable logic cell. A lookup table with four inputs and a clocked single-bit register sit side by side inside it. A 16-bit truth-table mask sets the table's function. Each of the two general outputs picks, on its own, either the combinational table result or the register. This lets the cell show the same result before and after the register at once. It also lets the register do work unrelated to the table: in packed mode the register loads a separate data input while the table result drives the other output.

An arithmetic mode makes the cell one bit of an adder. The result becomes the sum of operand bits 0 and 1 and the incoming carry. A carry-out is formed for the next higher cell. With the register bypassed the cell is a plain adder bit. With the register's output fed back as operand 1 and the sum captured, it acts as one bit of an accumulator. A dedicated chain output ANDs the table result with a chain input from a neighbouring cell, so that wide AND-style functions can be built across several cells.

Top module: `lec_cell`

## Requirements
- R1: In normal mode (`cfg_arith`=0), the table result equals `cfg_mask[lut_in]`, with `lut_in[0]` the least significant index bit.
- R2: In arithmetic mode, the table result is `lut_in[0] ^ opB ^ carry_in`. Here opB is `lut_in[1]`, or the register when `cfg_fb`=1. `lut_in[3:2]` and the mask have no effect.
- R3: In arithmetic mode, `carry_out` = (opA & opB) | (carry_in & (opA ^ opB)). In normal mode `carry_out` is 0.
- R4: `chain_out` equals the table result ANDed with `chain_in` when `cfg_chain_en`=1. Otherwise it equals the table result.
- R5: `out0` and `out1` each show the table result when their select bit (`cfg_sel0`, `cfg_sel1`) is 0, and the register when it is 1.
- R6: When `cfg_pack`=0 and `ena`=1, the register loads the table result at the rising clock edge. With selects 0 and 1, the unregistered and registered versions appear together.
- R7: When `cfg_pack`=1 and `ena`=1, the register loads `pack_d`, while the table result still drives a 0-selected output unchanged.
- R8: When `ena`=0 and `clr`=0, the register keeps its value.
- R9: `clr` is a synchronous active-high clear. It sets the register to 0 at the next rising edge and overrides `ena`.
- R10: With `cfg_arith`=1 and `cfg_fb`=1, the cell accumulates: operand 1 is taken from the register, so that `lut_in[0]`=1 held over edges toggles the register and raises `carry_out` whenever the register is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous register clear, active high |
| ena | input | 1 | Register load enable |
| lut_in | input | LUT_K | Table index; bits 0 and 1 are the arithmetic operands |
| carry_in | input | 1 | Carry from the lower-order cell |
| chain_in | input | 1 | Chain input from the neighbouring cell |
| pack_d | input | 1 | Register data in packed mode |
| cfg_mask | input | 2**LUT_K | Truth-table mask |
| cfg_arith | input | 1 | 1 = arithmetic mode |
| cfg_chain_en | input | 1 | 1 = AND chain_in into chain_out |
| cfg_pack | input | 1 | 1 = register loads pack_d |
| cfg_fb | input | 1 | 1 = operand 1 taken from the register |
| cfg_sel0 | input | 1 | out0 source: 0 table, 1 register |
| cfg_sel1 | input | 1 | out1 source: 0 table, 1 register |
| out0 | output | 1 | General output 0 |
| out1 | output | 1 | General output 1 |
| carry_out | output | 1 | Carry to the higher-order cell |
| chain_out | output | 1 | Chain output |

## Verification
The hardest state to reach is the accumulator loop. In that loop the register feeds operand 1, and the next register value depends on the previous one. Any error in the feedback path shows up only after two or more edges. The bench clears the register, sets arithmetic and feedback modes, holds operand 0 high and checks the sum, the carry and the register over consecutive edges. It checks the register toggling 0, 1, 0 with the carry rising only while the register holds 1. Packed mode gets a similar treatment: the table mask is set to 0 while `pack_d` is 1. A register that wrongly loads the table result then stays visibly 0.

// File: rtl/lec_pkg.sv
package lec_pkg;
  // Output source encoding for each general output select bit
  typedef enum logic {
    SRC_LUT = 1'b0,
    SRC_REG = 1'b1
  } out_src_e;

  // Operand positions inside lut_in for arithmetic mode
  localparam int OP_A_IDX = 0;
  localparam int OP_B_IDX = 1;
endpackage

// File: rtl/lec_lut.sv
module lec_lut #(
  parameter int LUT_K  = 4,
  localparam int MASK_W = 2 ** LUT_K
) (
  input  logic [LUT_K-1:0]  idx,
  input  logic [MASK_W-1:0] mask,
  input  logic              arith,
  input  logic              op_a,
  input  logic              op_b,
  input  logic              cin,
  output logic              res
);
  logic norm_res;
  logic sum_res;

  // Normal mode: the mask is indexed directly by the inputs
  assign norm_res = mask[idx];

  // Arithmetic mode: sum part of the split table
  assign sum_res = op_a ^ op_b ^ cin;

  assign res = arith ? sum_res : norm_res;
endmodule

// File: rtl/lec_carry.sv
module lec_carry (
  input  logic op_a,
  input  logic op_b,
  input  logic cin,
  input  logic arith,
  input  logic lut_res,
  input  logic chain_in,
  input  logic chain_en,
  output logic cout,
  output logic chain_out
);
  logic gen;
  logic prop;

  assign gen  = op_a & op_b;
  assign prop = op_a ^ op_b;

  // Carry part: only active in arithmetic mode
  assign cout = arith & (gen | (cin & prop));

  // Chain: AND with the neighbour when enabled
  assign chain_out = chain_en ? (lut_res & chain_in) : lut_res;
endmodule

// File: rtl/lec_reg.sv
module lec_reg (
  input  logic clk,
  input  logic clr,
  input  logic ena,
  input  logic pack,
  input  logic lut_d,
  input  logic pack_d,
  output logic q
);
  logic d_sel;

  assign d_sel = pack ? pack_d : lut_d;

  always_ff @(posedge clk) begin
    if (clr) begin
      q <= 1'b0;
    end else if (ena) begin
      q <= d_sel;
    end
  end
endmodule

// File: rtl/lec_cell.sv
module lec_cell
  import lec_pkg::*;
#(
  parameter int LUT_K  = 4,
  localparam int MASK_W = 2 ** LUT_K
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              ena,
  input  logic [LUT_K-1:0]  lut_in,
  input  logic              carry_in,
  input  logic              chain_in,
  input  logic              pack_d,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic              cfg_arith,
  input  logic              cfg_chain_en,
  input  logic              cfg_pack,
  input  logic              cfg_fb,
  input  logic              cfg_sel0,
  input  logic              cfg_sel1,
  output logic              out0,
  output logic              out1,
  output logic              carry_out,
  output logic              chain_out
);
  logic op_a;
  logic op_b;
  logic lut_res;
  logic reg_q;
  logic [1:0] sel_vec;
  logic [1:0] out_vec;

  assign op_a = lut_in[OP_A_IDX];
  assign op_b = cfg_fb ? reg_q : lut_in[OP_B_IDX];

  lec_lut #(.LUT_K(LUT_K)) u_lut (
    .idx   (lut_in),
    .mask  (cfg_mask),
    .arith (cfg_arith),
    .op_a  (op_a),
    .op_b  (op_b),
    .cin   (carry_in),
    .res   (lut_res)
  );

  lec_carry u_carry (
    .op_a      (op_a),
    .op_b      (op_b),
    .cin       (carry_in),
    .arith     (cfg_arith),
    .lut_res   (lut_res),
    .chain_in  (chain_in),
    .chain_en  (cfg_chain_en),
    .cout      (carry_out),
    .chain_out (chain_out)
  );

  lec_reg u_reg (
    .clk    (clk),
    .clr    (clr),
    .ena    (ena),
    .pack   (cfg_pack),
    .lut_d  (lut_res),
    .pack_d (pack_d),
    .q      (reg_q)
  );

  // Independent source selection per general output
  assign sel_vec = {cfg_sel1, cfg_sel0};

  for (genvar g = 0; g < 2; g++) begin : g_out
    assign out_vec[g] = (out_src_e'(sel_vec[g]) == SRC_REG) ? reg_q : lut_res;
  end

  assign out0 = out_vec[0];
  assign out1 = out_vec[1];
endmodule

// File: rtl/lec_cell_chk.sv
module lec_cell_chk #(
  parameter int LUT_K = 4
) (
  input logic             clk,
  input logic             clr,
  input logic             ena,
  input logic             cfg_pack,
  input logic             cfg_arith,
  input logic             cfg_chain_en,
  input logic             cfg_fb,
  input logic [LUT_K-1:0] lut_in,
  input logic             lut_res,
  input logic             reg_q,
  input logic             pack_d,
  input logic             carry_out,
  input logic             chain_out
);
  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) clr |=> (reg_q == 1'b0)); // R9
  AST_HOLD_NO_ENA: assert property (@(posedge clk) disable iff (clr)
    (!clr && !ena) |=> $stable(reg_q)); // R8
  AST_CAPTURE_LUT: assert property (@(posedge clk) disable iff (clr)
    (!clr && ena && !cfg_pack) |=> (reg_q == $past(lut_res))); // R6
  AST_CAPTURE_PACK: assert property (@(posedge clk) disable iff (clr)
    (!clr && ena && cfg_pack) |=> (reg_q == $past(pack_d))); // R7
  AST_NO_CARRY_NORMAL: assert property (@(posedge clk) disable iff (clr)
    !cfg_arith |-> !carry_out); // R3
  AST_CARRY_GEN_KILL: assert property (@(posedge clk) disable iff (clr)
    (cfg_arith && !cfg_fb && (lut_in[0] == lut_in[1])) |-> (carry_out == lut_in[0])); // R3
  AST_CHAIN_PASS: assert property (@(posedge clk) disable iff (clr)
    !cfg_chain_en |-> (chain_out == lut_res)); // R4
endmodule

bind lec_cell lec_cell_chk #(.LUT_K(LUT_K)) u_chk (
  .clk          (clk),
  .clr          (clr),
  .ena          (ena),
  .cfg_pack     (cfg_pack),
  .cfg_arith    (cfg_arith),
  .cfg_chain_en (cfg_chain_en),
  .cfg_fb       (cfg_fb),
  .lut_in       (lut_in),
  .lut_res      (lut_res),
  .reg_q        (reg_q),
  .pack_d       (pack_d),
  .carry_out    (carry_out),
  .chain_out    (chain_out)
);

// File: tb/lec_cell_bench.sv
module lec_cell_bench;
  localparam int CLK_PERIOD = 10;
  localparam int K = 4;
  localparam int NVEC = 11;

  // {mask[26:11], in[10:7], cin[6], chain_in[5], arith[4], chain_en[3], e_res[2], e_cout[1], e_chain[0]}
  localparam logic [26:0] VEC [NVEC] = '{
    {16'h8000, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {16'h8000, 4'hE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'h0001, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h6996, 4'h7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {16'h6996, 4'h3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'hFFFF, 4'h3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'hFFFF, 4'h1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h0000, 4'hC, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {16'h0000, 4'h3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {16'h0000, 4'h2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {16'hFFFF, 4'h5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic clr, ena, carry_in, chain_in, pack_d;
  logic [K-1:0] lut_in;
  logic [15:0] cfg_mask;
  logic cfg_arith, cfg_chain_en, cfg_pack, cfg_fb, cfg_sel0, cfg_sel1;
  logic out0, out1, carry_out, chain_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lec_cell #(.LUT_K(K)) u_lec_cell (
    .clk(clk), .clr(clr), .ena(ena), .lut_in(lut_in), .carry_in(carry_in),
    .chain_in(chain_in), .pack_d(pack_d), .cfg_mask(cfg_mask),
    .cfg_arith(cfg_arith), .cfg_chain_en(cfg_chain_en), .cfg_pack(cfg_pack),
    .cfg_fb(cfg_fb), .cfg_sel0(cfg_sel0), .cfg_sel1(cfg_sel1),
    .out0(out0), .out1(out1), .carry_out(carry_out), .chain_out(chain_out)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Wait for the rising edge, then settle before sampling
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    clr = 1'b1; ena = 1'b0; lut_in = '0; carry_in = 1'b0; chain_in = 1'b0;
    pack_d = 1'b0; cfg_mask = '0; cfg_arith = 1'b0; cfg_chain_en = 1'b0;
    cfg_pack = 1'b0; cfg_fb = 1'b0; cfg_sel0 = 1'b1; cfg_sel1 = 1'b1;
    tick(); tick();
    check("R9", "reset out0", out0, 1'b0);
    check("R9", "reset out1", out1, 1'b0);

    // Table-driven combinational checks
    @(negedge clk);
    clr = 1'b0; cfg_sel0 = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      cfg_mask     = VEC[i][26:11];
      lut_in       = VEC[i][10:7];
      carry_in     = VEC[i][6];
      chain_in     = VEC[i][5];
      cfg_arith    = VEC[i][4];
      cfg_chain_en = VEC[i][3];
      #1;
      check(cfg_arith ? "R2" : "R1", $sformatf("vec %0d result", i), out0, VEC[i][2]);
      check("R3", $sformatf("vec %0d carry", i), carry_out, VEC[i][1]);
      check("R4", $sformatf("vec %0d chain", i), chain_out, VEC[i][0]);
    end

    // R5/R6: registered and unregistered versions together
    @(negedge clk);
    cfg_arith = 1'b0; cfg_chain_en = 1'b0; carry_in = 1'b0;
    cfg_mask = 16'h0010; lut_in = 4'h4; cfg_sel0 = 1'b0; cfg_sel1 = 1'b1; ena = 1'b1;
    #1;
    check("R5", "out0 shows table before edge", out0, 1'b1);
    check("R5", "out1 shows register before edge", out1, 1'b0);
    tick();
    check("R6", "out1 registered copy", out1, 1'b1);
    check("R6", "out0 unregistered copy", out0, 1'b1);

    // R8: enable low holds while the table changes
    @(negedge clk);
    ena = 1'b0; lut_in = 4'h0;
    tick();
    check("R8", "hold with ena low", out1, 1'b1);
    check("R5", "out0 follows table", out0, 1'b0);

    // R9: clear overrides enable
    @(negedge clk);
    ena = 1'b1; clr = 1'b1; lut_in = 4'h4;
    tick();
    check("R9", "clear over enable", out1, 1'b0);

    // R7: packed register loads pack_d; table stays 0 on out0
    @(negedge clk);
    clr = 1'b0; cfg_pack = 1'b1; pack_d = 1'b1; cfg_mask = 16'h0000;
    tick();
    check("R7", "packed register", out1, 1'b1);
    check("R7", "table output unchanged", out0, 1'b0);
    @(negedge clk);
    pack_d = 1'b0;
    tick();
    check("R7", "packed register reload", out1, 1'b0);

    // R10: accumulator bit with feedback
    @(negedge clk);
    cfg_pack = 1'b0; cfg_arith = 1'b1; cfg_fb = 1'b1; lut_in = 4'h1; carry_in = 1'b0;
    clr = 1'b1;
    tick();
    @(negedge clk);
    clr = 1'b0;
    #1;
    check("R10", "acc sum at q=0", out0, 1'b1);
    check("R10", "acc carry at q=0", carry_out, 1'b0);
    tick();
    check("R10", "acc register step1", out1, 1'b1);
    check("R10", "acc sum at q=1", out0, 1'b0);
    check("R10", "acc carry at q=1", carry_out, 1'b1);
    tick();
    check("R10", "acc register step2", out1, 1'b0);
    check("R10", "acc carry back low", carry_out, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule